// File: doc/BRIEF.md
# Standard-Definition Field Check Word Inserter

This block sits in a 10-bit standard-definition component video path and handles one data word per clock. It keeps two running 16-bit checksums for each field. The active-picture sum covers the picture words of the active lines. The full-field sum covers every word of the field except the check packet's own slot. At each field change it captures both sums. Later in the next field, once the active picture has ended, it writes them into the stream as a formatted ancillary packet.

The block also reads any packet that already sits in that slot. It compares the checksums carried there with the ones it captured, and it carries forward the error indications from upstream. The outgoing flag word reports what went wrong here and what went wrong upstream. Each reported error also sets a sticky status bit, which a clear strobe resets.

An enable input turns insertion on. A force input writes the packet even when the incoming slot holds no packet. Both inputs are sampled at the timing word that opens the slot. Outside replaced slots, the output is the input delayed by one clock.

Top module: `edh_gen`

## Requirements
- R1: vid_out equals vid_in from one clock earlier for every word that is not replaced. This includes all words outside the slot, and all slot words when replacement is off.
- R2: A timing sequence is 3FFh, 000h, 000h followed by a word whose bit 8 is F, bit 7 is V and bit 6 is H (1 marks end of line). A field starts at such a word whose F differs from the previous one, except for the first one seen after reset. At that word both running sums are captured as the previous field's results and marked valid, and both sums restart.
- R3: Each sum uses the polynomial x^16+x^12+x^5+1. It starts at zero and takes each 10-bit word LSB first. The full-field sum includes the field-start word and every later word outside the slot. The active sum covers the ACT_WORDS words that follow a start-of-line timing word with V=0.
- R4: The slot is the 13 words after the first end-of-line timing word with V=1 that follows one with V=0. The packet in the slot is: 000h, 3FFh, 3FFh, identifier EDH_DID, count 7, three active-sum words, three full-field-sum words, flag word, checksum word.
- R5: Every formatted word carries an 8-bit payload b in bits 7:0. Bit 8 is the XOR of b and bit 9 is the inverse of bit 8. For a sum c, the first word has c[5:0] in b[7:2] and the second has c[11:6] in b[7:2]. The third has c[15:12] in b[5:2] and the valid bit in b[7]. All other payload bits are zero.
- R6: Bits 8:0 of the checksum word are the 9-bit sum of bits 8:0 of words 3 to 11. Bit 9 is the inverse of bit 8.
- R7: The slot is replaced when enable is high and either force is high or incoming words 0 to 4 match the template. Otherwise the slot passes through unchanged.
- R8: Flag bit 0 (active) and bit 2 (full field) are set when all of the following hold: the incoming header matched, the received valid bit is 1, the local results are valid, and the received sum differs from the captured one.
- R9: Flag bit 1 is set when received flag bit 0 or bit 1 is set. Flag bit 3 is set when received flag bit 2 or bit 3 is set. Both apply only when the incoming header matched.
- R10: edh_sts bits are set by the flags of each inserted packet and stay set. A high sts_clr clears them on the next clock, and a new set in the same clock takes priority over the clear.
- R11: After reset, vid_out and edh_sts are zero, both captured sums are zero and their valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | 10 | Incoming video word |
| edh_en | input | 1 | Insertion enable |
| edh_force | input | 1 | Insert even without an incoming packet |
| sts_clr | input | 1 | Clear strobe for the sticky status |
| vid_out | output | 10 | Outgoing video word, one clock later |
| edh_sts | output | 4 | Sticky flags: 0 active error here, 1 active error upstream, 2 field error here, 3 field error upstream |

## Verification
The bench builds the block with ACT_WORDS set to 8 and the default identifier. Each field is seven 32-word lines, so a field is about 224 words. Many field changes therefore fit into a short run: captured sums, valid-bit start-up, matched and missing packets, corrupted sums and propagated upstream flags are all reached within a few thousand clocks. The random fields vary enable, force, packet presence, sum corruption and received flags together.

// File: rtl/edh_pkg.sv
package edh_pkg;
    localparam int unsigned WORD_W   = 10;
    localparam int unsigned SUM_W    = 16;
    localparam logic [15:0] SUM_POLY = 16'h1021;
    localparam int unsigned PKT_LEN  = 13;
    localparam logic [7:0]  PKT_DC   = 8'd7;
    localparam logic [9:0]  TRS_ONES = 10'h3FF;
    localparam logic [9:0]  TRS_ZERO = 10'h000;

    // one 10-bit word into the running sum, least significant bit first
    function automatic logic [SUM_W-1:0] sum_step(input logic [SUM_W-1:0] c,
                                                   input logic [WORD_W-1:0] w);
        logic [SUM_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[SUM_W-1] ^ w[i];
            r  = {r[SUM_W-2:0], 1'b0};
            if (fb) r = r ^ SUM_POLY;
        end
        return r;
    endfunction

    // payload byte with even parity in bit 8 and its inverse in bit 9
    function automatic logic [WORD_W-1:0] fmt_word(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction
endpackage

// File: rtl/edh_trs.sv
module edh_trs
    import edh_pkg::*;
#(
    parameter int unsigned ACT_WORDS = 1440
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              fld_start_o,
    output logic              ap_take_o,
    output logic              slot_go_o
);
    localparam int unsigned CW = $clog2(ACT_WORDS + 1);

    typedef struct packed {
        logic [2:0][WORD_W-1:0] hist;
        logic                   fld;
        logic                   seen;
        logic                   last_v;
        logic [CW-1:0]          apc;
    } trs_t;

    trs_t s_q, s_d;
    logic xyz_hit, sav_hit, eav_hit;

    always_comb begin
        s_d     = s_q;
        xyz_hit = (s_q.hist[2] == TRS_ONES) && (s_q.hist[1] == TRS_ZERO)
                  && (s_q.hist[0] == TRS_ZERO);
        sav_hit = xyz_hit && !word_i[6];
        eav_hit = xyz_hit && word_i[6];

        fld_start_o = xyz_hit && s_q.seen && (word_i[8] != s_q.fld);
        slot_go_o   = eav_hit && word_i[7] && !s_q.last_v;
        ap_take_o   = (s_q.apc != '0);

        s_d.hist = {s_q.hist[1:0], word_i};
        if (sav_hit && !word_i[7]) begin
            s_d.apc = CW'(ACT_WORDS);
        end else if (s_q.apc != '0) begin
            s_d.apc = s_q.apc - 1'b1;
        end
        if (xyz_hit) begin
            s_d.fld  = word_i[8];
            s_d.seen = 1'b1;
        end
        if (eav_hit) begin
            s_d.last_v = word_i[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.last_v <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/edh_sum.sv
module edh_sum
    import edh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              restart_i,
    input  logic              take_i,
    output logic [SUM_W-1:0]  res_o
);
    typedef struct packed {
        logic [SUM_W-1:0] run;
        logic [SUM_W-1:0] res;
    } sum_t;

    sum_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.res = s_q.run;
            s_d.run = take_i ? sum_step('0, word_i) : '0;
        end else if (take_i) begin
            s_d.run = sum_step(s_q.run, word_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_o = s_q.res;
endmodule

// File: rtl/edh_pkt.sv
module edh_pkt
    import edh_pkg::*;
#(
    parameter logic [7:0] EDH_DID = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              slot_go_i,
    input  logic              fld_start_i,
    input  logic [SUM_W-1:0]  ap_res_i,
    input  logic [SUM_W-1:0]  ff_res_i,
    input  logic              en_i,
    input  logic              force_i,
    input  logic              clr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              slot_act_o,
    output logic [3:0]        slot_idx_o,
    output logic              repl_o,
    output logic [3:0]        sts_o,
    output logic [3:0]        sts_set_o,
    output logic              ok_o
);
    localparam logic [3:0] LAST_IDX = 4'(PKT_LEN - 1);

    typedef struct packed {
        logic [WORD_W-1:0] out;
        logic              act;
        logic [3:0]        idx;
        logic              match;
        logic              en;
        logic              frc;
        logic [11:0]       rx_ap;
        logic [11:0]       rx_ff;
        logic              ap_bad;
        logic              ff_bad;
        logic [8:0]        cs;
        logic              ok;
        logic [3:0]        sts;
    } pkt_t;

    pkt_t s_q, s_d;
    logic [WORD_W-1:0] hdr_w, tmpl_w;
    logic              m_now;
    logic [3:0]        flags;

    always_comb begin
        s_d = s_q;

        case (s_q.idx)
            4'd0:    hdr_w = TRS_ZERO;
            4'd1:    hdr_w = TRS_ONES;
            4'd2:    hdr_w = TRS_ONES;
            4'd3:    hdr_w = fmt_word(EDH_DID);
            4'd4:    hdr_w = fmt_word(PKT_DC);
            default: hdr_w = '0;
        endcase

        m_now = s_q.match && ((s_q.idx > 4'd4) || (word_i == hdr_w));
        flags = {m_now & (word_i[2] | word_i[3]), s_q.ff_bad,
                 m_now & (word_i[0] | word_i[1]), s_q.ap_bad};

        case (s_q.idx)
            4'd5:    tmpl_w = fmt_word({ap_res_i[5:0], 2'b00});
            4'd6:    tmpl_w = fmt_word({ap_res_i[11:6], 2'b00});
            4'd7:    tmpl_w = fmt_word({s_q.ok, 1'b0, ap_res_i[15:12], 2'b00});
            4'd8:    tmpl_w = fmt_word({ff_res_i[5:0], 2'b00});
            4'd9:    tmpl_w = fmt_word({ff_res_i[11:6], 2'b00});
            4'd10:   tmpl_w = fmt_word({s_q.ok, 1'b0, ff_res_i[15:12], 2'b00});
            4'd11:   tmpl_w = fmt_word({4'b0000, flags});
            4'd12:   tmpl_w = {~s_q.cs[8], s_q.cs};
            default: tmpl_w = hdr_w;
        endcase

        repl_o    = s_q.act && s_q.en && (s_q.frc || m_now);
        sts_set_o = (s_q.act && (s_q.idx == 4'd11) && repl_o) ? flags : 4'b0000;

        s_d.out = repl_o ? tmpl_w : word_i;
        s_d.ok  = s_q.ok | fld_start_i;
        s_d.sts = (clr_i ? 4'b0000 : s_q.sts) | sts_set_o;

        if (slot_go_i && !s_q.act) begin
            s_d.act    = 1'b1;
            s_d.idx    = '0;
            s_d.match  = 1'b1;
            s_d.en     = en_i;
            s_d.frc    = force_i;
            s_d.rx_ap  = '0;
            s_d.rx_ff  = '0;
            s_d.ap_bad = 1'b0;
            s_d.ff_bad = 1'b0;
            s_d.cs     = '0;
        end else if (s_q.act) begin
            s_d.idx = s_q.idx + 4'd1;
            if (s_q.idx == LAST_IDX) s_d.act = 1'b0;
            if ((s_q.idx <= 4'd4) && (word_i != hdr_w)) s_d.match = 1'b0;
            if ((s_q.idx >= 4'd3) && (s_q.idx <= 4'd11)) s_d.cs = s_q.cs + tmpl_w[8:0];
            if (m_now) begin
                case (s_q.idx)
                    4'd5:  s_d.rx_ap[5:0]  = word_i[7:2];
                    4'd6:  s_d.rx_ap[11:6] = word_i[7:2];
                    4'd7:  s_d.ap_bad = word_i[7] && s_q.ok
                                        && ({word_i[5:2], s_q.rx_ap} != ap_res_i);
                    4'd8:  s_d.rx_ff[5:0]  = word_i[7:2];
                    4'd9:  s_d.rx_ff[11:6] = word_i[7:2];
                    4'd10: s_d.ff_bad = word_i[7] && s_q.ok
                                        && ({word_i[5:2], s_q.rx_ff} != ff_res_i);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o     = s_q.out;
    assign slot_act_o = s_q.act;
    assign slot_idx_o = s_q.idx;
    assign sts_o      = s_q.sts;
    assign ok_o       = s_q.ok;
endmodule

// File: rtl/edh_gen.sv
module edh_gen
    import edh_pkg::*;
#(
    parameter int unsigned ACT_WORDS = 1440,
    parameter logic [7:0]  EDH_DID   = 8'hF4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  vid_in,
    input  logic        edh_en,
    input  logic        edh_force,
    input  logic        sts_clr,
    output logic [9:0]  vid_out,
    output logic [3:0]  edh_sts
);
    localparam int unsigned N_SUMS = 2;

    logic                         fld_start, ap_take, slot_go;
    logic                         slot_act, repl, cap_ok;
    logic [3:0]                   slot_idx, sts_set;
    logic [N_SUMS-1:0]            take;
    logic [N_SUMS-1:0][SUM_W-1:0] res;

    edh_trs #(.ACT_WORDS(ACT_WORDS)) u_trs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (vid_in),
        .fld_start_o (fld_start),
        .ap_take_o   (ap_take),
        .slot_go_o   (slot_go)
    );

    // index 0: active picture, index 1: full field
    assign take = {~slot_act, ap_take};

    for (genvar g = 0; g < N_SUMS; g++) begin : g_sum
        edh_sum u_sum (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_i    (vid_in),
            .restart_i (fld_start),
            .take_i    (take[g]),
            .res_o     (res[g])
        );
    end

    edh_pkt #(.EDH_DID(EDH_DID)) u_pkt (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (vid_in),
        .slot_go_i   (slot_go),
        .fld_start_i (fld_start),
        .ap_res_i    (res[0]),
        .ff_res_i    (res[1]),
        .en_i        (edh_en),
        .force_i     (edh_force),
        .clr_i       (sts_clr),
        .word_o      (vid_out),
        .slot_act_o  (slot_act),
        .slot_idx_o  (slot_idx),
        .repl_o      (repl),
        .sts_o       (edh_sts),
        .sts_set_o   (sts_set),
        .ok_o        (cap_ok)
    );
endmodule

// File: rtl/edh_gen_chk.sv
module edh_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] vid_in,
    input logic [9:0] vid_out,
    input logic       clr,
    input logic [3:0] sts,
    input logic [3:0] sts_set,
    input logic       act,
    input logic [3:0] idx,
    input logic       repl,
    input logic       fld_start,
    input logic       ok
);
    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (vid_out == $past(vid_in)));

    // R4
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> ($past(idx) == 4'd12));

    // R5
    word_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl && (idx >= 4'd3)) |=> (vid_out[9] != vid_out[8]));

    // R2
    capture_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start |=> ok);

    // R10
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (sts_set == 4'b0000)) |=> (sts == 4'b0000));

    // R10
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sts & $past(sts)) == $past(sts)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> ((vid_out == 10'h000) && (sts == 4'b0000) && !act && !ok));
endmodule

bind edh_gen edh_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vid_in    (vid_in),
    .vid_out   (vid_out),
    .clr       (sts_clr),
    .sts       (edh_sts),
    .sts_set   (sts_set),
    .act       (slot_act),
    .idx       (slot_idx),
    .repl      (repl),
    .fld_start (fld_start),
    .ok        (cap_ok)
);

// File: tb/test_edh_gen.sv
module test_edh_gen;
    localparam int ACT   = 8;
    localparam int BLANK = 16;
    localparam int LINES = 7;
    localparam int PKT   = 13;
    localparam logic [7:0] DID = 8'hF4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vid_in = 10'h000;
    logic       edh_en = 1'b0, edh_force = 1'b0, sts_clr = 1'b0;
    logic [9:0] vid_out;
    logic [3:0] edh_sts;

    edh_gen #(.ACT_WORDS(ACT), .EDH_DID(DID)) i_edh_gen (
        .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .edh_en(edh_en),
        .edh_force(edh_force), .sts_clr(sts_clr), .vid_out(vid_out), .edh_sts(edh_sts)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [9:0]  exp_prev;
    bit          have_prev = 1'b0;
    string       tag_prev;
    logic [15:0] m_ap = 16'h0, m_ff = 16'h0, r_ap = 16'h0, r_ff = 16'h0;
    bit          r_ok = 1'b0, seen = 1'b0, cur_f = 1'b0, last_v = 1'b1;
    logic [3:0]  exp_sts = 4'h0;
    bit          drv_clr = 1'b0, clr_req = 1'b0, sts_pending = 1'b0;
    bit          s_pkt, s_bad_ap, s_bad_ff, s_rxv;
    logic [3:0]  s_rxf;

    function automatic logic [15:0] crc_w(input logic [15:0] c, input logic [9:0] w);
        logic [15:0] r = c;
        for (int i = 0; i < 10; i++) begin
            logic fb = r[15] ^ w[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [9:0] fmt8(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    function automatic logic [9:0] sum_word(input logic [15:0] c, input bit v, input int k);
        if (k == 0) return fmt8({c[5:0], 2'b00});
        if (k == 1) return fmt8({c[11:6], 2'b00});
        return fmt8({v, 1'b0, c[15:12], 2'b00});
    endfunction

    function automatic logic [9:0] filler();
        return 10'($urandom_range(4, 1019));
    endfunction

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %03h expected %03h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [9:0] w, input bit ap, input bit sl, input bit fs,
                       input logic [9:0] e, input string tag);
        @(negedge clk);
        if (have_prev) check(tag_prev, vid_out, exp_prev);
        if (sts_pending) begin
            check("R10 status", {6'h0, edh_sts}, {6'h0, exp_sts});
            sts_pending = 1'b0;
        end
        vid_in  = w;
        sts_clr = drv_clr;
        drv_clr = 1'b0;
        if (fs) begin
            r_ap = m_ap; r_ff = m_ff; r_ok = 1'b1;
            m_ff = crc_w(16'h0, w);
            m_ap = 16'h0;
        end else begin
            if (!sl) m_ff = crc_w(m_ff, w);
            if (ap)  m_ap = crc_w(m_ap, w);
        end
        exp_prev  = e;
        tag_prev  = tag;
        have_prev = 1'b1;
    endtask

    task automatic trs(input bit f, input bit v, input bit h);
        logic [9:0] x = {1'b1, f, v, h, 6'h00};
        bit fs = seen && (f != cur_f);
        put(10'h3FF, 0, 0, 0, 10'h3FF, "R1");
        put(10'h000, 0, 0, 0, 10'h000, "R1");
        put(10'h000, 0, 0, 0, 10'h000, "R1");
        put(x, 0, 0, fs, x, "R1 R2");
        seen = 1'b1;
        cur_f = f;
    endtask

    task automatic slot_words();
        logic [9:0]  iw [PKT];
        logic [9:0]  ow [PKT];
        logic [3:0]  fl;
        logic [15:0] ca, cf;
        logic [8:0]  s;
        bit          rep;
        string       tg;
        ca = r_ap ^ (s_bad_ap ? 16'h0100 : 16'h0);
        cf = r_ff ^ (s_bad_ff ? 16'h0020 : 16'h0);
        if (s_pkt) begin
            iw[0] = 10'h000; iw[1] = 10'h3FF; iw[2] = 10'h3FF;
            iw[3] = fmt8(DID); iw[4] = fmt8(8'd7);
            for (int k = 0; k < 3; k++) begin
                iw[5+k] = sum_word(ca, s_rxv, k);
                iw[8+k] = sum_word(cf, s_rxv, k);
            end
            iw[11] = fmt8({4'h0, s_rxf});
            s = 9'h0;
            for (int k = 3; k < 12; k++) s = s + iw[k][8:0];
            iw[12] = {~s[8], s};
        end else begin
            for (int k = 0; k < PKT; k++) iw[k] = filler();
        end
        rep   = edh_en && (edh_force || s_pkt);
        fl[0] = s_pkt && s_rxv && r_ok && (ca != r_ap);
        fl[1] = s_pkt && (s_rxf[0] | s_rxf[1]);
        fl[2] = s_pkt && s_rxv && r_ok && (cf != r_ff);
        fl[3] = s_pkt && (s_rxf[2] | s_rxf[3]);
        ow[0] = 10'h000; ow[1] = 10'h3FF; ow[2] = 10'h3FF;
        ow[3] = fmt8(DID); ow[4] = fmt8(8'd7);
        for (int k = 0; k < 3; k++) begin
            ow[5+k] = sum_word(r_ap, r_ok, k);
            ow[8+k] = sum_word(r_ff, r_ok, k);
        end
        ow[11] = fmt8({4'h0, fl});
        s = 9'h0;
        for (int k = 3; k < 12; k++) s = s + ow[k][8:0];
        ow[12] = {~s[8], s};
        if (rep) exp_sts = exp_sts | fl;
        for (int k = 0; k < PKT; k++) begin
            if (!rep)        tg = "R7 pass";
            else if (k < 5)  tg = "R4 R7 header";
            else if (k < 11) tg = "R2 R3 R5 sum word";
            else if (k == 11) tg = "R8 R9 flags";
            else             tg = "R6 checksum";
            put(iw[k], 0, 1, 0, rep ? ow[k] : iw[k], tg);
        end
    endtask

    task automatic line(input int l, input bit f);
        bit v = (l < 2) || (l > 4);
        bit is_slot = v && !last_v;
        logic [9:0] w;
        if (l == 0 || l == 2) sts_pending = 1'b1;
        if (l == 1 && clr_req) begin
            drv_clr = 1'b1; exp_sts = 4'h0; clr_req = 1'b0;
        end
        trs(f, v, 1'b1);
        last_v = v;
        if (is_slot) begin
            slot_words();
            for (int k = PKT; k < BLANK; k++) begin
                w = filler(); put(w, 0, 0, 0, w, "R1");
            end
        end else begin
            for (int k = 0; k < BLANK; k++) begin
                w = filler(); put(w, 0, 0, 0, w, "R1");
            end
        end
        trs(f, v, 1'b0);
        for (int k = 0; k < ACT; k++) begin
            w = filler(); put(w, !v, 0, 0, w, "R1 R3");
        end
    endtask

    task automatic field(input bit f, input bit en, input bit frc, input bit pkt,
                         input bit bad_ap, input bit bad_ff, input logic [3:0] rxf);
        edh_en = en; edh_force = frc;
        s_pkt = pkt; s_bad_ap = bad_ap; s_bad_ff = bad_ff; s_rxf = rxf; s_rxv = r_ok;
        for (int l = 0; l < LINES; l++) line(l, f);
    endtask

    initial begin
        logic [9:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R11 reset vid_out", vid_out, 10'h000);
        check("R11 reset status", {6'h0, edh_sts}, 10'h000);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            w = filler(); put(w, 0, 0, 0, w, "R1");
        end
        field(0, 1, 0, 1, 0, 0, 4'h0);   // R11 zero sums, valid 0
        field(1, 1, 0, 1, 0, 0, 4'h0);   // matching sums
        field(0, 1, 0, 1, 1, 0, 4'h4);   // R8 active mismatch, R9 upstream field flag
        clr_req = 1'b1;
        field(1, 1, 1, 0, 0, 0, 4'h0);   // R7 forced, R10 cleared
        field(0, 1, 0, 0, 0, 0, 4'h0);   // R7 no packet, no force
        field(1, 0, 1, 1, 1, 1, 4'hF);   // R7 disabled
        field(0, 1, 0, 1, 0, 1, 4'h1);   // R8 field mismatch, R9 upstream active flag
        for (int n = 0; n < 6; n++) begin
            if (n == 3) clr_req = 1'b1;
            field(n[0] ? 1'b0 : 1'b1, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)));
        end
        sts_pending = 1'b1;
        w = filler(); put(w, 0, 0, 0, w, "R1");
        w = filler(); put(w, 0, 0, 0, w, "R1");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule